// File: doc/BRIEF.md
# DDR Read Return Pipeline

This block produces the read side of a double-data-rate memory data bus. A read request is taken on a rising clock edge. After a programmable number of clocks the block streams a burst of words. Each clock carries two of them: one for the rising phase and one for the falling phase. A strobe is driven in step with the data, so its transitions line up with the data transitions. An internal source generates the burst contents from the request address. It follows the programmed burst length and burst ordering, so the bus output is fully determined by the requests and the configuration.

The request side is a valid/ready handshake. `rd_ready` drops while an accepted burst still has clocks left to issue, which stops bursts from overlapping. A request presented while `rd_ready` is low is held off and not taken. The data bus itself has no back-pressure: once a request is accepted, its beats appear at fixed times. A request that arrives exactly as the previous burst ends continues the bus with no idle clock.

The strobe has a one-clock low preamble before a burst and a half-clock low postamble after it. Its drivers are released outside these windows. Configuration loads are accepted only when no read is in flight and the encoding is legal. Any other load is refused and signalled with a one-clock error pulse.

Top module: `ddr_rd_return`

## Requirements
- R1: A configuration load is accepted only if `cfg_lat` is 2 or 3 (clocks of read latency) and `cfg_bl` is 1, 2 or 3 (burst of 2, 4 or 8 beats, i.e. 1, 2 or 4 clocks). Otherwise `cfg_err` is high for the clock after the load edge and the previous settings stay in force.
- R2: A read accepted at edge n with latency m gives `dq_oe` high first in the clock that starts at edge n+m.
- R3: In each data clock, `dq_rise` carries beat 2j and `dq_fall` carries beat 2j+1 of the burst, where j counts data clocks from 0.
- R4: `dq_oe` stays high for exactly BL/2 consecutive clocks per burst.
- R5: With `cfg_ilv`=0 (sequential), beat k has address bits above log2(BL) taken from the request address and low bits (start+k) mod BL, where start is the request address mod BL.
- R6: With `cfg_ilv`=1 (interleaved), the low log2(BL) bits of beat k are start XOR k.
- R7: In every data clock, `dqs` is 1 (high in the rising phase, low in the falling phase) and both strobe enables are high. Outside data clocks, `dqs` is 0.
- R8: The clock before a burst that does not continue another burst is a preamble. In it `dqs_pre`=1 and both strobe enables are high, with the strobe low.
- R9: The clock after a burst that is not followed at once by another burst is a postamble. In it `dqs_post`=1, `dqs_oe_rise`=1 and `dqs_oe_fall`=0.
- R10: A read accepted exactly BL/2 clocks after the previous one streams with no idle clock, and without a preamble or postamble between the two bursts.
- R11: After a request is accepted, `rd_ready` is low for BL/2-1 clocks, then high again.
- R12: A configuration load is refused with `cfg_err` in these cases: it comes while a read is in flight (from acceptance through its postamble), or at the same edge as an accepted read.
- R13: Reset clears all in-flight reads, deasserts every data and strobe enable, and restores latency 2, burst 4, sequential order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Request to load a new configuration |
| cfg_lat | input | 2 | Read latency in clocks (2 or 3 legal) |
| cfg_bl | input | 2 | Burst code: 1=2 beats, 2=4, 3=8; 0 reserved |
| cfg_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cfg_err | output | 1 | One-clock pulse: last load refused |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be accepted this edge |
| rd_addr | input | DW | Start address of the burst |
| dq_oe | output | 1 | Data bus driven this clock |
| dq_rise | output | DW | Word on the rising phase |
| dq_fall | output | DW | Word on the falling phase |
| dqs | output | 1 | Strobe level in the rising phase (low in the falling phase) |
| dqs_oe_rise | output | 1 | Strobe driven in the rising phase |
| dqs_oe_fall | output | 1 | Strobe driven in the falling phase |
| dqs_pre | output | 1 | Preamble clock flag |
| dqs_post | output | 1 | Postamble clock flag |

## Verification
Two things can land on the same clock edge: a configuration load and the acceptance of a read. The bench provokes this by presenting `cfg_load` together with `rd_valid` while `rd_ready` is high. It expects the load to be refused with `cfg_err`, and the read to keep the old latency, length and order. A second collision is also driven on purpose: a burst reload on the very clock where a postamble would start. Back-to-back requests timed exactly one burst apart provoke it, and the bench judges it by the absence of both the postamble and the preamble flags while data continues unbroken.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // deepest programmable latency; sizes the command delay line
  localparam int unsigned LAT_MAX = 3;

  typedef struct packed {
    logic [1:0] bl;   // burst code: 1,2,3 -> 2,4,8 beats
    logic       ilv;  // interleaved order when set
  } rd_meta_t;

  function automatic logic lat_legal(input logic [1:0] lat);
    return (lat == 2'd2) || (lat == 2'd3);
  endfunction

  function automatic logic bl_legal(input logic [1:0] bl);
    return bl != 2'd0;
  endfunction

  // data clocks of a burst, minus one
  function automatic logic [1:0] span_m1(input logic [1:0] bl);
    case (bl)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [2:0] wrap_mask(input logic [1:0] bl);
    case (bl)
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // low address bits of beat k within the burst
  function automatic logic [2:0] order_low(input logic [2:0] start, input logic [2:0] k,
                                           input logic [1:0] bl, input logic ilv);
    logic [2:0] m;
    m = wrap_mask(bl);
    if (ilv) return (start ^ k) & m;
    return (start + k) & m;
  endfunction

endpackage

// File: rtl/ddr_rd_cfg.sv
module ddr_rd_cfg
  import ddr_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic [1:0] cfg_lat,
  input  logic [1:0] cfg_bl,
  input  logic       cfg_ilv,
  input  logic       busy,
  output logic [1:0] lat_q,
  output logic [1:0] bl_q,
  output logic       ilv_q,
  output logic       cfg_err
);

  logic take;
  assign take = cfg_load && lat_legal(cfg_lat) && bl_legal(cfg_bl) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= 2'd2;
      bl_q    <= 2'd2;
      ilv_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_load && !take;
      if (take) begin
        lat_q <= cfg_lat;
        bl_q  <= cfg_bl;
        ilv_q <= cfg_ilv;
      end
    end
  end

  p_lat_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q == 2'd2) || (lat_q == 2'd3));

  p_hold_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lat_q) && $stable(bl_q) && $stable(ilv_q)));

endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched
  import ddr_rd_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = LAT_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_addr,
  input  logic [1:0]    lat_q,
  input  logic [1:0]    bl_q,
  input  logic          ilv_q,
  output logic          rd_ready,
  output logic          rd_acc,
  output logic          tap_v,
  output logic [DW-1:0] tap_addr,
  output rd_meta_t      tap_meta,
  output logic          pipe_busy
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]    gap;
  logic [DEPTH-1:0] st_v;
  logic [DW-1:0] st_a [DEPTH];
  rd_meta_t      st_m [DEPTH];
  logic [IW-1:0] tidx;

  assign rd_ready = (gap == 2'd0);
  assign rd_acc   = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= 2'd0;
    end else if (rd_acc) begin
      gap <= span_m1(bl_q);
    end else if (gap != 2'd0) begin
      gap <= gap - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v[0] <= 1'b0;
      st_a[0] <= '0;
      st_m[0] <= '0;
    end else begin
      st_v[0] <= rd_acc;
      st_a[0] <= rd_addr;
      st_m[0] <= '{bl: bl_q, ilv: ilv_q};
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v[i] <= 1'b0;
        st_a[i] <= '0;
        st_m[i] <= '0;
      end else begin
        st_v[i] <= st_v[i-1];
        st_a[i] <= st_a[i-1];
        st_m[i] <= st_m[i-1];
      end
    end
  end

  // a request sits lat-1 stages before the engine picks it up
  assign tidx      = IW'(lat_q - 2'd1);
  assign tap_v     = st_v[tidx];
  assign tap_addr  = st_a[tidx];
  assign tap_meta  = st_m[tidx];
  assign pipe_busy = |st_v;

  p_ready_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (bl_q != 2'd1)) |=> !rd_ready);

endmodule

// File: rtl/ddr_rd_beat.sv
module ddr_rd_beat
  import ddr_rd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tap_v,
  input  logic [DW-1:0] tap_addr,
  input  rd_meta_t      tap_meta,
  output logic          dq_oe,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dqs,
  output logic          dqs_oe_rise,
  output logic          dqs_oe_fall,
  output logic          dqs_pre,
  output logic          dqs_post,
  output logic          eng_busy
);

  logic          act, post;
  logic [DW-1:0] base;
  rd_meta_t      meta;
  logic [2:0]    idx;
  logic [1:0]    left;

  function automatic logic [DW-1:0] word_at(input logic [DW-1:0] a, input logic [2:0] k,
                                            input rd_meta_t md);
    logic [2:0] keep;
    keep = a[2:0] & ~wrap_mask(md.bl);
    return {a[DW-1:3], keep | order_low(a[2:0], k, md.bl, md.ilv)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      post    <= 1'b0;
      base    <= '0;
      meta    <= '0;
      idx     <= '0;
      left    <= '0;
      dq_rise <= '0;
      dq_fall <= '0;
    end else if (tap_v) begin
      // new burst, possibly continuing straight from the last one
      act     <= 1'b1;
      post    <= 1'b0;
      base    <= tap_addr;
      meta    <= tap_meta;
      idx     <= 3'd2;
      left    <= span_m1(tap_meta.bl);
      dq_rise <= word_at(tap_addr, 3'd0, tap_meta);
      dq_fall <= word_at(tap_addr, 3'd1, tap_meta);
    end else if (act && (left != 2'd0)) begin
      post    <= 1'b0;
      idx     <= idx + 3'd2;
      left    <= left - 2'd1;
      dq_rise <= word_at(base, idx, meta);
      dq_fall <= word_at(base, idx + 3'd1, meta);
    end else begin
      post <= act;
      act  <= 1'b0;
    end
  end

  assign dq_oe       = act;
  assign dqs         = act;
  assign dqs_pre     = tap_v && !act;
  assign dqs_post    = post;
  assign dqs_oe_rise = act || dqs_pre || post;
  assign dqs_oe_fall = act || dqs_pre;
  assign eng_busy    = act || post;

  p_pre_leads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |=> dq_oe);

  p_post_trails_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_post |-> (!dq_oe && $past(dq_oe)));

  p_seam_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && tap_v) |=> (dq_oe && !dqs_post));

endmodule

// File: rtl/ddr_rd_return.sv
module ddr_rd_return
  import ddr_rd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_lat,
  input  logic [1:0]    cfg_bl,
  input  logic          cfg_ilv,
  output logic          cfg_err,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [DW-1:0] rd_addr,
  output logic          dq_oe,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dqs,
  output logic          dqs_oe_rise,
  output logic          dqs_oe_fall,
  output logic          dqs_pre,
  output logic          dqs_post
);

  logic [1:0]    lat_q, bl_q;
  logic          ilv_q, rd_acc, tap_v, pipe_busy, eng_busy, busy_any;
  logic [DW-1:0] tap_addr;
  rd_meta_t      tap_meta;

  assign busy_any = pipe_busy || eng_busy || rd_acc;

  ddr_rd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lat(cfg_lat),
    .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .busy(busy_any),
    .lat_q(lat_q), .bl_q(bl_q), .ilv_q(ilv_q), .cfg_err(cfg_err)
  );

  ddr_rd_sched #(.DW(DW), .DEPTH(LAT_MAX)) u_sched (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .lat_q(lat_q), .bl_q(bl_q), .ilv_q(ilv_q), .rd_ready(rd_ready),
    .rd_acc(rd_acc), .tap_v(tap_v), .tap_addr(tap_addr), .tap_meta(tap_meta),
    .pipe_busy(pipe_busy)
  );

  ddr_rd_beat #(.DW(DW)) u_beat (
    .clk(clk), .rst_n(rst_n), .tap_v(tap_v), .tap_addr(tap_addr), .tap_meta(tap_meta),
    .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall), .dqs(dqs),
    .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall),
    .dqs_pre(dqs_pre), .dqs_post(dqs_post), .eng_busy(eng_busy)
  );

  // R2: the first data clock follows a latency-aligned pickup of the request
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(tap_v) && $past(dqs_pre)));

endmodule

// File: tb/tb_ddr_rd_return.sv
module tb_ddr_rd_return;

  localparam int NC = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0, cfg_ilv = 1'b0, rd_valid = 1'b0;
  logic [1:0] cfg_lat = 2'd0, cfg_bl = 2'd0;
  logic [7:0] rd_addr = 8'd0;
  logic       cfg_err, rd_ready, dq_oe, dqs, dqs_oe_rise, dqs_oe_fall, dqs_pre, dqs_post;
  logic [7:0] dq_rise, dq_fall;

  ddr_rd_return #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lat(cfg_lat), .cfg_bl(cfg_bl),
    .cfg_ilv(cfg_ilv), .cfg_err(cfg_err), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall), .dqs(dqs),
    .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall), .dqs_pre(dqs_pre),
    .dqs_post(dqs_post)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit d_v [NC];
  bit pre_m [NC];
  bit busy_m [NC];
  bit err_m [NC];
  logic [7:0] w_r [NC];
  logic [7:0] w_f [NC];
  int m_lat = 2, m_bl = 2, m_ilv = 0, next_free = 0;
  bit in_rst = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] beat_word(input logic [7:0] a, input int k, input int blc,
                                           input int ilv);
    int bl, s, low;
    bl  = 1 << blc;
    s   = int'(a) % bl;
    low = ilv ? (s ^ k) : ((s + k) % bl);
    return 8'(int'(a) - s + low);
  endfunction

  task automatic check_cycle(input int c);
    bit ev, ep, eq;
    if (c < 1 || c >= NC) return;
    ev = d_v[c];
    ep = pre_m[c] && !d_v[c];
    eq = d_v[c-1] && !d_v[c];
    if (in_rst)
      chk("R13 enables clear in reset", {dq_oe, dqs_oe_rise, dqs_oe_fall, dqs_pre, dqs_post}, 0);
    chk("R2 R4 R10 data enable", dq_oe, ev);
    if (ev) begin
      chk("R3 R5 R6 rising word", dq_rise, w_r[c]);
      chk("R3 R5 R6 falling word", dq_fall, w_f[c]);
    end
    chk("R7 strobe level", dqs, ev);
    chk("R7 R8 R9 strobe enable rise", dqs_oe_rise, ev || ep || eq);
    chk("R7 R8 strobe enable fall", dqs_oe_fall, ev || ep);
    chk("R8 R10 preamble flag", dqs_pre, ep);
    chk("R9 R10 postamble flag", dqs_post, eq);
    chk("R1 R12 config error", cfg_err, err_m[c]);
    chk("R11 request ready", rd_ready, (c + 1) >= next_free);
  endtask

  task automatic tick(input bit rv, input logic [7:0] a, input bit cl, input logic [1:0] l,
                      input logic [1:0] b, input bit il, input bit rs);
    int c, e, k;
    bit acc, ok;
    @(negedge clk);
    c = cyc;
    check_cycle(c);
    e = c + 1;
    if (rs) begin
      rst_n = 1'b0; rd_valid = 1'b0; cfg_load = 1'b0;
      for (int i = c; i < NC; i++) begin
        d_v[i] = 0; pre_m[i] = 0; busy_m[i] = 0; err_m[i] = 0;
      end
      next_free = 0; m_lat = 2; m_bl = 2; m_ilv = 0; in_rst = 1'b1;
      return;
    end
    rst_n = 1'b1; in_rst = 1'b0;
    rd_valid = rv; rd_addr = a; cfg_load = cl; cfg_lat = l; cfg_bl = b; cfg_ilv = il;
    acc = rv && (e >= next_free);
    if (acc) begin
      k = (1 << m_bl) / 2;
      if (e + m_lat + k + 1 < NC) begin
        for (int j = 0; j < k; j++) begin
          d_v[e + m_lat + j] = 1;
          w_r[e + m_lat + j] = beat_word(a, 2 * j, m_bl, m_ilv);
          w_f[e + m_lat + j] = beat_word(a, 2 * j + 1, m_bl, m_ilv);
        end
        pre_m[e + m_lat - 1] = 1;
        for (int j = e; j <= e + m_lat + k; j++) busy_m[j] = 1;
      end
      next_free = e + k;
    end
    if (cl && e < NC) begin
      ok = (l == 2 || l == 3) && (b != 0) && !busy_m[e - 1] && !acc;
      err_m[e] = !ok;
      if (ok) begin m_lat = l; m_bl = b; m_ilv = il; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00, 0, 2'd0, 2'd0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    // R13 reset state
    repeat (3) tick(0, 8'h00, 0, 2'd0, 2'd0, 0, 1);
    idle(2);
    // R2 R5 default latency 2, burst 4, sequential with a wrapping start
    tick(1, 8'h35, 0, 2'd0, 2'd0, 0, 0); idle(8);
    // R1 legal load: latency 3, burst 8
    tick(0, 8'h00, 1, 2'd3, 2'd3, 0, 0); idle(2);
    tick(1, 8'h13, 0, 2'd0, 2'd0, 0, 0); idle(10);
    // R10 R11 seamless burst-8 pair, plus an early request held off
    tick(1, 8'h40, 0, 2'd0, 2'd0, 0, 0);
    tick(1, 8'h50, 0, 2'd0, 2'd0, 0, 0); idle(2);
    tick(1, 8'h6D, 0, 2'd0, 2'd0, 0, 0); idle(12);
    // R6 interleaved, latency 2
    tick(0, 8'h00, 1, 2'd2, 2'd3, 1, 0); idle(2);
    tick(1, 8'hA6, 0, 2'd0, 2'd0, 0, 0);
    // R12 load while in flight is refused
    tick(0, 8'h00, 1, 2'd3, 2'd1, 0, 0); idle(8);
    // R12 load at the same edge as an accepted read
    tick(1, 8'h2B, 1, 2'd3, 2'd1, 0, 0); idle(10);
    // R1 reserved encodings refused
    tick(0, 8'h00, 1, 2'd1, 2'd2, 0, 0); idle(2);
    tick(0, 8'h00, 1, 2'd2, 2'd0, 0, 0); idle(2);
    // R4 R10 burst of 2, back to back every clock
    tick(0, 8'h00, 1, 2'd2, 2'd1, 0, 0); idle(2);
    tick(1, 8'h01, 0, 2'd0, 2'd0, 0, 0);
    tick(1, 8'h02, 0, 2'd0, 2'd0, 0, 0);
    tick(1, 8'h03, 0, 2'd0, 2'd0, 0, 0); idle(6);
    // R13 reset in the middle of a burst
    tick(0, 8'h00, 1, 2'd3, 2'd3, 0, 0); idle(2);
    tick(1, 8'h77, 0, 2'd0, 2'd0, 0, 0); idle(4);
    tick(0, 8'h00, 0, 2'd0, 2'd0, 0, 1); idle(6);
    // constrained random mix
    for (int i = 0; i < 2500; i++) begin
      bit rs;
      rs = ($urandom % 400) == 0;
      tick(($urandom % 3) == 0, 8'($urandom), ($urandom % 14) == 0,
           2'($urandom), 2'($urandom), 1'($urandom), rs);
    end
    idle(12);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule